// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Mailbox

This block lets two processors on a shared clock trade words, doorbell interrupts and a small set of status flags. Each processor sees a private register window: a control register, a status register, four transmit registers and four receive registers. A word one side writes into transmit slot n lands in receive slot n of the other side. Empty and full bits on both sides follow the word until the receiver reads it.

Next to the data path the block carries four doorbells per direction. Each has a request bit that stays set until the far side clears its pending bit. It also carries a 3-bit flag value that reaches the far side after a fixed two-cycle transfer, and a 2-bit report of the far core's power mode (0 run, 1 wait, 2 stop, 3 deep sleep). Each side has one interrupt line. It is the OR of that side's pending conditions, each gated by its enable bit.

Register window per side: word offset 0x00 control, 0x04 status, 0x10 + 4n transmit slot n, 0x20 + 4n receive slot n. Accesses whose two low address bits are not zero are ignored.

Top module: `msgu_top`

## Requirements
- R1: After reset both control registers read 0, both status registers read 0x00F0_0000 (every transmit slot empty, nothing full or pending) and both interrupt lines are low.
- R2: A write to transmit slot n of one side, made while that slot is empty, clears that side's status bit 23-n and sets the far side's status bit 27-n from the next cycle. The far side's receive slot n then reads the written word.
- R3: A read of receive slot n (read strobe asserted) returns the word and clears that side's status bit 27-n. It also sets the sender's status bit 23-n again, from the next cycle.
- R4: A write to a transmit slot that is not empty is ignored, and the far side keeps reading the earlier word.
- R5: Writing control bit 19-n as 1 sets the far side's status bit 31-n. Control bit 19-n then reads 1 until the far side clears that pending bit, and reads 0 after. Writing it as 0 changes nothing.
- R6: Writing status bit 31-n as 1 clears that side's pending doorbell n. Writing it as 0 changes nothing.
- R7: A control write whose flag update is accepted presents control bits 2..0 in the far side's status bits 2..0 two cycles after the write edge. The writer's status bit 4 reads 1 for those two cycles.
- R8: A control write made while the writer's status bit 4 is 1 leaves the outgoing flag value and the flag transfer unchanged. The enable and doorbell fields of that write still take effect.
- R9: Status bits 7..6 show the far core's power-mode input.
- R10: Status bit 5 reads 1 while any of that side's transmit slots is full, any of its doorbells is still pending at the far side, or its flag transfer is in progress, and reads 0 otherwise.
- R11: The interrupt line of a side is the OR over n of three terms: control bit 31-n AND status bit 31-n, control bit 27-n AND status bit 27-n, and control bit 23-n AND status bit 23-n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of both sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe (consumes a receive slot) |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational from address |
| a_irq | output | 1 | Side A interrupt line |
| a_pm | input | 2 | Power mode of core A, reported to side B |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe (consumes a receive slot) |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational from address |
| b_irq | output | 1 | Side B interrupt line |
| b_pm | input | 2 | Power mode of core B, reported to side A |

## Verification
Directed sequences come first. They cover one fill, overwrite and drain of a slot, which shows that full and empty move as a pair on both sides and that a blocked write leaves the old word in place. A doorbell is raised, a zero is written to the request and then to the pending bit, and the bell is finally cleared: this shows that request and pending are one shared state. Two back-to-back flag writes show the exact two-cycle delay and that the second write is refused. A seeded random mix of slot writes and reads, control and status writes and power-mode changes then runs on both sides. After every operation a bench model predicts every control, status and receive register and both interrupt lines, which catches any mixing of the two directions or wrong bit ordering.

// File: rtl/msgu_pkg.sv
`timescale 1ns/1ps
package msgu_pkg;
    localparam int unsigned NCH      = 4;   // mailbox slots / doorbells per direction
    localparam int unsigned DW       = 32;  // register width
    localparam int unsigned FW       = 3;   // flag field width
    localparam int unsigned PMW      = 2;   // power-mode field width
    localparam int unsigned AW       = 6;   // byte address width of one window
    localparam int unsigned FLAG_LAT = 2;   // cycles from accepted flag write to far side
    localparam int unsigned CNTW     = $clog2(FLAG_LAT + 1);

    // top bits of the four indexed fields (index n sits at TOP-n)
    localparam int unsigned BELL_TOP = 31;
    localparam int unsigned FULL_TOP = 27;
    localparam int unsigned EMPT_TOP = 23;
    localparam int unsigned REQ_TOP  = 19;

    // word selects (byte address >> 2)
    localparam logic [AW-3:0] SEL_CTRL = 4'd0;
    localparam logic [AW-3:0] SEL_STAT = 4'd1;
    localparam logic [AW-3:0] SEL_TX0  = 4'd4;
    localparam logic [AW-3:0] SEL_RX0  = 4'd8;

    typedef logic [NCH-1:0] chvec_t;

    // index n <-> bit (NCH-1-n) of a field; self-inverse
    function automatic chvec_t flip(input chvec_t v);
        chvec_t r;
        for (int i = 0; i < NCH; i++) r[NCH-1-i] = v[i];
        return r;
    endfunction

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] data;
        chvec_t                 full;
        chvec_t                 bell;
        logic [FW-1:0]          stage;
        logic [FW-1:0]          flags;
        logic [CNTW-1:0]        cnt;
    } link_st_t;

    typedef struct packed {
        chvec_t        bell_en;
        chvec_t        full_en;
        chvec_t        empt_en;
        logic [FW-1:0] flags;
    } port_st_t;
endpackage

// File: rtl/msgu_link.sv
`timescale 1ns/1ps
// One direction of traffic: sender side writes, receiver side reads.
module msgu_link
    import msgu_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  chvec_t                 tx_wr_i,
    input  logic [DW-1:0]          tx_wdata_i,
    input  chvec_t                 rx_rd_i,
    input  chvec_t                 ring_i,
    input  chvec_t                 ack_i,
    input  logic                   flag_wr_i,
    input  logic [FW-1:0]          flag_wdata_i,
    output logic [NCH-1:0][DW-1:0] rx_data_o,
    output chvec_t                 full_o,
    output chvec_t                 bell_o,
    output logic [FW-1:0]          flags_o,
    output logic                   flag_pend_o,
    output logic                   busy_o
);
    link_st_t q, d;

    always_comb begin
        d = q;
        for (int n = 0; n < NCH; n++) begin
            if (rx_rd_i[n]) d.full[n] = 1'b0;
            if (tx_wr_i[n] && !q.full[n]) begin
                d.data[n] = tx_wdata_i;
                d.full[n] = 1'b1;
            end
            if (ack_i[n])  d.bell[n] = 1'b0;
            if (ring_i[n]) d.bell[n] = 1'b1;
        end
        if (q.cnt != '0) begin
            d.cnt = q.cnt - CNTW'(1);
            if (q.cnt == CNTW'(1)) d.flags = q.stage;
        end
        if (flag_wr_i && (q.cnt == '0)) begin
            d.stage = flag_wdata_i;
            d.cnt   = CNTW'(FLAG_LAT);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign rx_data_o   = q.data;
    assign full_o      = q.full;
    assign bell_o      = q.bell;
    assign flags_o     = q.flags;
    assign flag_pend_o = (q.cnt != '0);
    assign busy_o      = (|q.full) | (|q.bell) | flag_pend_o;

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        a_r2_fill_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!q.full[n] && !tx_wr_i[n]) |=> !q.full[n]);
        a_r4_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (q.full[n] && !rx_rd_i[n]) |=> (q.full[n] && $stable(q.data[n])));
        a_r3_read_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (q.full[n] && rx_rd_i[n]) |=> !q.full[n]);
        a_r6_bell_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (q.bell[n] && !ack_i[n]) |=> q.bell[n]);
    end

    a_r7_flags_move_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.cnt != CNTW'(1)) |=> $stable(q.flags));
    a_r8_refuse_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_wr_i && flag_pend_o) |=> $stable(q.stage));
endmodule

// File: rtl/msgu_port.sv
`timescale 1ns/1ps
// Register window of one side: decode, control state, read mux, interrupt.
module msgu_port
    import msgu_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   wr_en_i,
    input  logic                   rd_en_i,
    input  logic [AW-1:0]          addr_i,
    input  logic [DW-1:0]          wdata_i,
    output logic [DW-1:0]          rdata_o,
    output logic                   irq_o,
    input  logic [NCH-1:0][DW-1:0] rx_data_i,
    input  chvec_t                 rf_i,
    input  chvec_t                 te_i,
    input  chvec_t                 req_i,
    input  chvec_t                 pend_i,
    input  logic [FW-1:0]          peer_flags_i,
    input  logic                   fup_i,
    input  logic                   ep_i,
    input  logic [PMW-1:0]         pm_i,
    output chvec_t                 tx_wr_o,
    output logic [DW-1:0]          tx_wdata_o,
    output chvec_t                 rx_rd_o,
    output chvec_t                 ring_o,
    output chvec_t                 ack_o,
    output logic                   flag_wr_o,
    output logic [FW-1:0]          flag_wdata_o
);
    localparam int unsigned CR_GAP = DW - 4*NCH - FW;
    localparam int unsigned SR_GAP = DW - 3*NCH - PMW - 3 - FW;

    port_st_t       q, d;
    logic           aligned;
    logic [AW-3:0]  wsel;
    logic           ctrl_wr;
    logic [DW-1:0]  ctrl_rd, stat_rd;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign wsel    = addr_i[AW-1:2];
    assign ctrl_wr = wr_en_i && aligned && (wsel == SEL_CTRL);

    always_comb begin
        d         = q;
        tx_wr_o   = '0;
        rx_rd_o   = '0;
        ring_o    = '0;
        ack_o     = '0;
        flag_wr_o = 1'b0;
        if (ctrl_wr) begin
            d.bell_en = flip(wdata_i[BELL_TOP -: NCH]);
            d.full_en = flip(wdata_i[FULL_TOP -: NCH]);
            d.empt_en = flip(wdata_i[EMPT_TOP -: NCH]);
            ring_o    = flip(wdata_i[REQ_TOP -: NCH]);
            flag_wr_o = 1'b1;
            if (!fup_i) d.flags = wdata_i[FW-1:0];
        end
        if (wr_en_i && aligned && (wsel == SEL_STAT))
            ack_o = flip(wdata_i[BELL_TOP -: NCH]);
        for (int n = 0; n < NCH; n++) begin
            if (wr_en_i && aligned && (wsel == SEL_TX0 + (AW-2)'(n))) tx_wr_o[n] = 1'b1;
            if (rd_en_i && aligned && (wsel == SEL_RX0 + (AW-2)'(n))) rx_rd_o[n] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign tx_wdata_o   = wdata_i;
    assign flag_wdata_o = wdata_i[FW-1:0];

    assign ctrl_rd = {flip(q.bell_en), flip(q.full_en), flip(q.empt_en), flip(req_i),
                      {CR_GAP{1'b0}}, q.flags};
    assign stat_rd = {flip(pend_i), flip(rf_i), flip(te_i), {SR_GAP{1'b0}},
                      pm_i, ep_i, fup_i, 1'b0, peer_flags_i};

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            if (wsel == SEL_CTRL) rdata_o = ctrl_rd;
            if (wsel == SEL_STAT) rdata_o = stat_rd;
            for (int n = 0; n < NCH; n++)
                if (wsel == SEL_RX0 + (AW-2)'(n)) rdata_o = rx_data_i[n];
        end
    end

    assign irq_o = (|(q.bell_en & pend_i)) | (|(q.full_en & rf_i)) | (|(q.empt_en & te_i));

    a_r11_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.bell_en == '0 && q.full_en == '0 && q.empt_en == '0) |-> !irq_o);
    a_r8_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr && fup_i) |=> $stable(q.flags));
endmodule

// File: rtl/msgu_top.sv
`timescale 1ns/1ps
module msgu_top
    import msgu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           a_wr_en,
    input  logic           a_rd_en,
    input  logic [AW-1:0]  a_addr,
    input  logic [DW-1:0]  a_wdata,
    output logic [DW-1:0]  a_rdata,
    output logic           a_irq,
    input  logic [PMW-1:0] a_pm,
    input  logic           b_wr_en,
    input  logic           b_rd_en,
    input  logic [AW-1:0]  b_addr,
    input  logic [DW-1:0]  b_wdata,
    output logic [DW-1:0]  b_rdata,
    output logic           b_irq,
    input  logic [PMW-1:0] b_pm
);
    // index 0 = side A, 1 = side B; link s carries traffic sent by side s
    logic [1:0]                   wr_en, rd_en, irq, flag_wr, fpend, busy;
    logic [1:0][AW-1:0]           addr;
    logic [1:0][DW-1:0]           wdata, rdata, tx_wdata;
    logic [1:0][PMW-1:0]          pm;
    logic [1:0][FW-1:0]           flag_wdata, flags;
    chvec_t [1:0]                 tx_wr, rx_rd, ring, ack, full, bell;
    logic [1:0][NCH-1:0][DW-1:0]  rx_data;

    assign wr_en = {b_wr_en, a_wr_en};
    assign rd_en = {b_rd_en, a_rd_en};
    assign addr  = {b_addr, a_addr};
    assign wdata = {b_wdata, a_wdata};
    assign pm    = {b_pm, a_pm};
    assign a_rdata = rdata[0];
    assign b_rdata = rdata[1];
    assign a_irq   = irq[0];
    assign b_irq   = irq[1];

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam int P = 1 - s;

        msgu_link u_link (
            .clk_i        (clk),
            .rst_ni       (rst_n),
            .tx_wr_i      (tx_wr[s]),
            .tx_wdata_i   (tx_wdata[s]),
            .rx_rd_i      (rx_rd[P]),
            .ring_i       (ring[s]),
            .ack_i        (ack[P]),
            .flag_wr_i    (flag_wr[s]),
            .flag_wdata_i (flag_wdata[s]),
            .rx_data_o    (rx_data[s]),
            .full_o       (full[s]),
            .bell_o       (bell[s]),
            .flags_o      (flags[s]),
            .flag_pend_o  (fpend[s]),
            .busy_o       (busy[s])
        );

        msgu_port u_port (
            .clk_i        (clk),
            .rst_ni       (rst_n),
            .wr_en_i      (wr_en[s]),
            .rd_en_i      (rd_en[s]),
            .addr_i       (addr[s]),
            .wdata_i      (wdata[s]),
            .rdata_o      (rdata[s]),
            .irq_o        (irq[s]),
            .rx_data_i    (rx_data[P]),
            .rf_i         (full[P]),
            .te_i         (~full[s]),
            .req_i        (bell[s]),
            .pend_i       (bell[P]),
            .peer_flags_i (flags[P]),
            .fup_i        (fpend[s]),
            .ep_i         (busy[s]),
            .pm_i         (pm[P]),
            .tx_wr_o      (tx_wr[s]),
            .tx_wdata_o   (tx_wdata[s]),
            .rx_rd_o      (rx_rd[s]),
            .ring_o       (ring[s]),
            .ack_o        (ack[s]),
            .flag_wr_o    (flag_wr[s]),
            .flag_wdata_o (flag_wdata[s])
        );
    end
endmodule

// File: tb/test_msgu_top.sv
`timescale 1ns/1ps
module test_msgu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr_en = 0, a_rd_en = 0, b_wr_en = 0, b_rd_en = 0;
    logic [5:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0, a_rdata, b_rdata;
    logic        a_irq, b_irq;
    logic [1:0]  a_pm = 0, b_pm = 0;

    always #5 clk = ~clk;

    msgu_top i_msgu_top (.*);

    // ---------------- model (direction index = sending side) ----------------
    logic [31:0] m_data [2][4];
    logic [3:0]  m_full [2], m_bell [2], m_gen [2], m_rfe [2], m_tee [2];
    logic [2:0]  m_crf [2], m_stage [2], m_flags [2];
    int          m_cnt [2];
    logic [1:0]  m_pm [2];
    int          n_cmp = 0, n_bad = 0;
    logic [31:0] last_rd;
    bit          done = 0;

    function automatic bit m_busy(int s);
        return (|m_full[s]) || (|m_bell[s]) || (m_cnt[s] != 0);
    endfunction

    function automatic logic [31:0] exp_sr(int s);
        logic [31:0] r = '0;
        int p = 1 - s;
        for (int n = 0; n < 4; n++) begin
            r[31-n] = m_bell[p][n];
            r[27-n] = m_full[p][n];
            r[23-n] = ~m_full[s][n];
        end
        r[7:6] = m_pm[p];
        r[5]   = m_busy(s);
        r[4]   = (m_cnt[s] != 0);
        r[2:0] = m_flags[p];
        return r;
    endfunction

    function automatic logic [31:0] exp_cr(int s);
        logic [31:0] r = '0;
        for (int n = 0; n < 4; n++) begin
            r[31-n] = m_gen[s][n];
            r[27-n] = m_rfe[s][n];
            r[23-n] = m_tee[s][n];
            r[19-n] = m_bell[s][n];
        end
        r[2:0] = m_crf[s];
        return r;
    endfunction

    function automatic logic exp_irq(int s);
        return (|(m_gen[s] & m_bell[1-s])) | (|(m_rfe[s] & m_full[1-s])) |
               (|(m_tee[s] & ~m_full[s]));
    endfunction

    function automatic void model_apply(int s, bit wr, bit rd, logic [5:0] a, logic [31:0] w);
        bit acc = (m_cnt[s] == 0);
        for (int d = 0; d < 2; d++) begin
            if (m_cnt[d] != 0) begin
                if (m_cnt[d] == 1) m_flags[d] = m_stage[d];
                m_cnt[d]--;
            end
        end
        if (a[1:0] != 0) return;
        if (wr) begin
            if (a == 6'h00) begin
                for (int n = 0; n < 4; n++) begin
                    m_gen[s][n] = w[31-n];
                    m_rfe[s][n] = w[27-n];
                    m_tee[s][n] = w[23-n];
                    if (w[19-n]) m_bell[s][n] = 1'b1;
                end
                if (acc) begin
                    m_crf[s] = w[2:0]; m_stage[s] = w[2:0]; m_cnt[s] = 2;
                end
            end else if (a == 6'h04) begin
                for (int n = 0; n < 4; n++) if (w[31-n]) m_bell[1-s][n] = 1'b0;
            end else if (a >= 6'h10 && a <= 6'h1C) begin
                int n = int'(a[3:2]);
                if (!m_full[s][n]) begin m_data[s][n] = w; m_full[s][n] = 1'b1; end
            end
        end
        if (rd && a >= 6'h20 && a <= 6'h2C) m_full[1-s][int'(a[3:2])] = 1'b0;
    endfunction

    // ---------------- checking ----------------
    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        a_addr = 6'h00; b_addr = 6'h00; #0.3;
        chk(a_rdata == exp_cr(0), {tag, " control A"}, a_rdata, exp_cr(0));
        chk(b_rdata == exp_cr(1), {tag, " control B"}, b_rdata, exp_cr(1));
        a_addr = 6'h04; b_addr = 6'h04; #0.3;
        chk(a_rdata == exp_sr(0), {tag, " status A"}, a_rdata, exp_sr(0));
        chk(b_rdata == exp_sr(1), {tag, " status B"}, b_rdata, exp_sr(1));
        chk(a_irq == exp_irq(0), {tag, " R11 irq A"}, 32'(a_irq), 32'(exp_irq(0)));
        chk(b_irq == exp_irq(1), {tag, " R11 irq B"}, 32'(b_irq), 32'(exp_irq(1)));
        for (int n = 0; n < 4; n++) begin
            a_addr = 6'h20 + 6'(4*n); b_addr = 6'h20 + 6'(4*n); #0.3;
            if (m_full[1][n]) chk(a_rdata == m_data[1][n], {tag, " R2 receive A"}, a_rdata, m_data[1][n]);
            if (m_full[0][n]) chk(b_rdata == m_data[0][n], {tag, " R2 receive B"}, b_rdata, m_data[0][n]);
        end
    endtask

    task automatic op(int s, bit wr, bit rd, logic [5:0] a, logic [31:0] w, string tag);
        @(negedge clk);
        if (s == 0) begin a_wr_en = wr; a_rd_en = rd; a_addr = a; a_wdata = w; end
        else        begin b_wr_en = wr; b_rd_en = rd; b_addr = a; b_wdata = w; end
        #1 last_rd = (s == 0) ? a_rdata : b_rdata;
        @(posedge clk);
        model_apply(s, wr, rd, a, w);
        #1;
        a_wr_en = 0; a_rd_en = 0; b_wr_en = 0; b_rd_en = 0;
        check_all(tag);
    endtask

    task automatic idle(string tag);
        op(0, 0, 0, 6'h00, 32'h0, tag);
    endtask

    task automatic set_pm(int s, logic [1:0] v);
        if (s == 0) a_pm = v; else b_pm = v;
        m_pm[s] = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog R1 actual=%h expected=%h", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_full[s] = 0; m_bell[s] = 0; m_gen[s] = 0; m_rfe[s] = 0; m_tee[s] = 0;
            m_crf[s] = 0; m_stage[s] = 0; m_flags[s] = 0; m_cnt[s] = 0; m_pm[s] = 0;
            for (int n = 0; n < 4; n++) m_data[s][n] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state
        check_all("R1");
        a_addr = 6'h04; b_addr = 6'h04; #0.3;
        chk(a_rdata == 32'h00F0_0000, "R1 status A after reset", a_rdata, 32'h00F0_0000);
        chk(b_rdata == 32'h00F0_0000, "R1 status B after reset", b_rdata, 32'h00F0_0000);

        // R2 fill, R4 blocked overwrite, R3 drain
        op(0, 1, 0, 6'h14, 32'hDEAD_BEEF, "R2");
        b_addr = 6'h04; #0.3;
        chk(b_rdata[26] == 1'b1, "R2 full bit B", b_rdata, 32'h1 << 26);
        op(0, 1, 0, 6'h14, 32'h1234_5678, "R4");
        b_addr = 6'h24; #0.3;
        chk(b_rdata == 32'hDEAD_BEEF, "R4 old word kept", b_rdata, 32'hDEAD_BEEF);
        op(1, 0, 1, 6'h24, 32'h0, "R3");
        chk(last_rd == 32'hDEAD_BEEF, "R3 read data", last_rd, 32'hDEAD_BEEF);
        a_addr = 6'h04; #0.3;
        chk(a_rdata[22] == 1'b1, "R3 empty bit A back", a_rdata, 32'h1 << 22);

        // R5/R6 doorbell 2
        op(0, 1, 0, 6'h00, 32'h0002_0000, "R5");
        b_addr = 6'h04; a_addr = 6'h00; #0.3;
        chk(b_rdata[29] == 1'b1, "R5 pending B bit29", b_rdata, 32'h1 << 29);
        chk(a_rdata[17] == 1'b1, "R5 request A bit17", a_rdata, 32'h1 << 17);
        op(0, 1, 0, 6'h00, 32'h0, "R5");
        op(1, 1, 0, 6'h04, 32'h0, "R6");
        op(1, 1, 0, 6'h04, 32'h2000_0000, "R6");
        a_addr = 6'h00; #0.3;
        chk(a_rdata[17] == 1'b0, "R6 request A released", a_rdata, 32'h0);
        repeat (3) idle("R7");

        // R7/R8 flags
        op(0, 1, 0, 6'h00, 32'h0000_0005, "R7");
        op(0, 1, 0, 6'h00, 32'h0000_0003, "R8");
        idle("R7");
        b_addr = 6'h04; a_addr = 6'h00; #0.3;
        chk(b_rdata[2:0] == 3'd5, "R7 flags at B", 32'(b_rdata[2:0]), 32'd5);
        chk(a_rdata[2:0] == 3'd5, "R8 flags A kept", 32'(a_rdata[2:0]), 32'd5);

        // R9 power mode
        set_pm(1, 2'd2);
        idle("R9");
        a_addr = 6'h04; #0.3;
        chk(a_rdata[7:6] == 2'd2, "R9 peer mode", 32'(a_rdata[7:6]), 32'd2);

        // R10 event pending
        op(0, 1, 0, 6'h10, 32'hA5A5_0001, "R10");
        op(1, 0, 1, 6'h20, 32'h0, "R10");

        // R11 interrupt enables
        op(1, 1, 0, 6'h00, 32'h0800_0005, "R11");
        op(0, 1, 0, 6'h10, 32'h0BAD_F00D, "R11");
        op(1, 0, 1, 6'h20, 32'h0, "R11");
        op(0, 1, 0, 6'h00, 32'h00F0_0005, "R11");

        // random mix
        void'($urandom(32'h0000_5EED));
        for (int i = 0; i < 600; i++) begin
            int s = int'($urandom % 2);
            int k = int'($urandom % 9);
            int n = int'($urandom % 4);
            logic [31:0] w = $urandom;
            case (k)
                0, 1, 2: op(s, 1, 0, 6'h10 + 6'(4*n), w, "R2 random");
                3, 4:    op(s, 0, 1, 6'h20 + 6'(4*n), 32'h0, "R3 random");
                5: begin
                    w = w & 32'hFFF0_0007;
                    if ($urandom % 3 == 0) w[19:16] = 4'($urandom);
                    op(s, 1, 0, 6'h00, w, "R5 random");
                end
                6: op(s, 1, 0, 6'h04, w, "R6 random");
                7: begin set_pm(s, 2'($urandom)); idle("R9 random"); end
                default: op(s, 1, 0, 6'h01, w, "R4 random");
            endcase
        end
        finish_run();
    end
endmodule